// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is a free-running up-counter for general timing work. Software reaches it through a simple single-cycle register port. A functional clock enable paces the count. The count can be slowed by a power-of-two prescaler, and it reloads from a load register when it wraps past its all-ones value. It can also raise a compare event when it reaches a programmed match value. A single packed control word sets every mode.

Three event sources sit behind an interrupt status register, an interrupt enable register and a wakeup enable register. They are match (bit 0), overflow (bit 1) and a capture source (bit 2) that this block never raises itself. An enabled event latches into status and holds the interrupt line high. Software clears status by writing ones. A separate wakeup line pulses once for each event whose wakeup bit is set.

One output pin can follow the overflow and match events, either by toggling or by emitting a single-cycle pulse. It can also sit at a programmable default level.

Register byte offsets:

| Offset | Register | Access |
|--------|----------|--------|
| 0x10 | configuration | bit 1 soft reset, reads 0 |
| 0x14 | reset-done | reads 1 |
| 0x18 | status | write one to clear |
| 0x1C | interrupt enable | read/write |
| 0x20 | wakeup enable | read/write |
| 0x24 | control | read/write |
| 0x28 | counter | read/write |
| 0x2C | load | read/write |
| 0x30 | trigger | write only |
| 0x34 | write-pending | reads 0 |
| 0x38 | match | read/write |
| 0x40 | interface control | bit 1 soft reset, reads 0 |

Top module: `tick_match_timer`

## Requirements
- R1: After reset every register reads 0, except offset 0x14, which reads 1. Offset 0x34 always reads 0. irq, wake and pin_out are low and pin_oe is high.
- R2: The counter advances only when control bit 0 (run) is 1 and fclk_en is high. With bit 5 clear it adds one on each such cycle. While run is 0 it holds and raises no events.
- R3: When control bit 5 is set, the counter advances once every 2^(P+1) enabled cycles, where P is control bits 4:2. Any write to the control register restarts that prescale count from zero.
- R4: On an advance from 0xFFFFFFFF the counter takes the load register value and raises the overflow event (bit 1). If control bit 1 (auto-reload) is 0, run also clears, unless the control register is being written in that cycle.
- R5: When control bit 6 is set, the match event (bit 0) fires on the advance that brings the counter to the match register value, including the case where the value comes from a reload.
- R6: An event whose interrupt-enable bit is set sets the status bit of the same position one cycle later. irq is high while status is nonzero. Writing status clears the bits written as one. A new event wins over a clear in the same cycle.
- R7: The interrupt enable and wakeup enable registers keep only bits 2:0. The control register keeps bits 14:0, and all of them read back, including bits 9:8 and 13.
- R8: Each event whose wakeup-enable bit is set produces a one-cycle high on wake in the next cycle, whatever the interrupt enables hold.
- R9: A counter write loads the written value, and a trigger register write loads the load value. Either write takes priority over an advance in the same cycle.
- R10: When control bits 11:10 are 0 or 3, pin_out equals control bit 7 (default level).
- R11: With bit 12 set, the pin toggles one cycle after each trigger event. In mode 1 the trigger event is overflow; in mode 2 it is overflow or match. Each control write sets the toggle state to the written bit 7.
- R12: With bit 12 clear in modes 1 and 2, pin_out equals bit 7 inverted for exactly the one cycle that follows each trigger event.
- R13: When control bit 14 is 1, pin_oe is low and trigger events do not change the pin state.
- R14: Writing a one in bit 1 of offset 0x10 or of offset 0x40 returns all timer state to its reset value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| fclk_en | input | 1 | functional clock enable that paces the count |
| reg_wr | input | 1 | write strobe for one cycle |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| irq | output | 1 | interrupt, high while status is nonzero |
| wake | output | 1 | one-cycle wakeup pulse |
| pin_out | output | 1 | output pin level |
| pin_oe | output | 1 | output pin drive enable |

## Verification
The properties assume the register port is used one access at a time: a single write strobe per cycle, always to one of the listed offsets, and no write in the cycle whose hold or reload behaviour they examine. The stimulus keeps to this. Each cycle makes at most one write, and the addresses come only from the register table. Counter, load and match values are drawn near zero or just below the wrap point, so that overflow, reload-onto-match and one-shot stops occur often while the random sequences still fit in a short run.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
   localparam int CTRL_W = 15;
   localparam int NUM_EV = 3;
   localparam int PTV_W  = 3;

   localparam logic [7:0] OFS_CFG   = 8'h10;
   localparam logic [7:0] OFS_RDONE = 8'h14;
   localparam logic [7:0] OFS_STAT  = 8'h18;
   localparam logic [7:0] OFS_IEN   = 8'h1C;
   localparam logic [7:0] OFS_WEN   = 8'h20;
   localparam logic [7:0] OFS_CTRL  = 8'h24;
   localparam logic [7:0] OFS_CNT   = 8'h28;
   localparam logic [7:0] OFS_LOAD  = 8'h2C;
   localparam logic [7:0] OFS_TRIG  = 8'h30;
   localparam logic [7:0] OFS_PEND  = 8'h34;
   localparam logic [7:0] OFS_MATCH = 8'h38;
   localparam logic [7:0] OFS_IFC   = 8'h40;

   typedef enum logic [1:0] {
      PIN_HOLD = 2'd0,
      PIN_OVF  = 2'd1,
      PIN_BOTH = 2'd2,
      PIN_RSVD = 2'd3
   } pin_mode_t;

   // field order fixes the bit positions of the control word
   typedef struct packed {
      logic             dir_in;
      logic             capt_pair;
      logic             toggle;
      pin_mode_t        pmode;
      logic [1:0]       capt_edge;
      logic             dflt;
      logic             cmp_en;
      logic             pre_en;
      logic [PTV_W-1:0] ptv;
      logic             reload;
      logic             run;
   } ctrl_t;
endpackage

// File: rtl/tmt_prescale.sv
module tmt_prescale #(
   parameter int PTV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             clr,
   input  logic             run,
   input  logic             fclk_en,
   input  logic             pre_en,
   input  logic [PTV_W-1:0] ptv,
   output logic             tick
);
   localparam int SH_W = PTV_W + 1;
   localparam int PS_W = 1 << PTV_W;

   logic [PS_W-1:0] pcnt, lim;
   logic            adv;

   assign lim  = ~({PS_W{1'b1}} << ({1'b0, ptv} + SH_W'(1)));
   assign adv  = run && fclk_en;
   assign tick = adv && (!pre_en || pcnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (srst || clr)      pcnt <= '0;
      else if (adv && pre_en)    pcnt <= (pcnt == lim) ? '0 : pcnt + 1'b1;
   end
endmodule

// File: rtl/tmt_count.sv
module tmt_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         tick,
   input  logic         cmp_en,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] load_q,
   input  logic [W-1:0] match_q,
   output logic [W-1:0] cnt_q,
   output logic         ovf,
   output logic         mat
);
   logic [W-1:0] nxt;

   assign ovf = tick && (cnt_q == {W{1'b1}});
   assign nxt = ovf ? load_q : cnt_q + 1'b1;
   assign mat = tick && cmp_en && (nxt == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (srst)  cnt_q <= '0;
      else if (ld)    cnt_q <= ld_val;
      else if (tick)  cnt_q <= nxt;
   end
endmodule

// File: rtl/tmt_events.sv
module tmt_events #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [N-1:0] ev,
   input  logic         wr_stat,
   input  logic         wr_ien,
   input  logic         wr_wen,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] status,
   output logic [N-1:0] ien,
   output logic [N-1:0] wen,
   output logic         irq,
   output logic         wake
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     status[i] <= 1'b0;
         else if (srst)  status[i] <= 1'b0;
         else            status[i] <= (ev[i] && ien[i]) ||
                                      (status[i] && !(wr_stat && wbits[i]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien <= '0; wen <= '0; wake <= 1'b0;
      end else if (srst) begin
         ien <= '0; wen <= '0; wake <= 1'b0;
      end else begin
         if (wr_ien) ien <= wbits;
         if (wr_wen) wen <= wbits;
         wake <= |(ev & wen);
      end
   end

   assign irq = |status;
endmodule

// File: rtl/tmt_pin.sv
module tmt_pin
   import tmt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      srst,
   input  logic      ctrl_wr,
   input  logic      wr_dflt,
   input  pin_mode_t pmode,
   input  logic      toggle,
   input  logic      dflt,
   input  logic      dir_in,
   input  logic      ovf,
   input  logic      mat,
   output logic      pin_out,
   output logic      pin_oe
);
   logic tog_q, pls_q, hit, act;

   assign hit = (pmode == PIN_OVF  && ovf) ||
                (pmode == PIN_BOTH && (ovf || mat));
   assign act = hit && !dir_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0; pls_q <= 1'b0;
      end else if (srst) begin
         tog_q <= 1'b0; pls_q <= 1'b0;
      end else begin
         pls_q <= act && !toggle;
         if (ctrl_wr)              tog_q <= wr_dflt;
         else if (act && toggle)   tog_q <= ~tog_q;
      end
   end

   always_comb begin
      if (pmode == PIN_HOLD || pmode == PIN_RSVD) pin_out = dflt;
      else if (toggle)                            pin_out = tog_q;
      else                                        pin_out = dflt ^ pls_q;
   end
   assign pin_oe = !dir_in;
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
   import tmt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fclk_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              irq,
   output logic              wake,
   output logic              pin_out,
   output logic              pin_oe
);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_RDONE = ADDR_W'(OFS_RDONE);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_WEN   = ADDR_W'(OFS_WEN);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFS_TRIG);
   localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
   localparam logic [ADDR_W-1:0] A_IFC   = ADDR_W'(OFS_IFC);

   if (CNT_W < CTRL_W) begin : g_bad_cnt_w
      $error("tick_match_timer: CNT_W must hold the control word");
   end
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("tick_match_timer: ADDR_W too small for the register map");
   end

   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  load_q, match_q, cnt_q;
   logic [NUM_EV-1:0] status, ien, wen, ev;
   logic              tick, ovf, mat, srst, wr_ctrl, wr_cnt, wr_trig;

   assign srst    = reg_wr && (reg_addr == A_CFG || reg_addr == A_IFC) && reg_wdata[1];
   assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
   assign wr_cnt  = reg_wr && reg_addr == A_CNT;
   assign wr_trig = reg_wr && reg_addr == A_TRIG;
   assign ev      = {1'b0, ovf, mat};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; load_q <= '0; match_q <= '0;
      end else if (srst) begin
         ctrl_q <= '0; load_q <= '0; match_q <= '0;
      end else begin
         if (wr_ctrl)                  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         else if (ovf && !ctrl_q.reload) ctrl_q.run <= 1'b0;
         if (reg_wr && reg_addr == A_LOAD)  load_q  <= reg_wdata;
         if (reg_wr && reg_addr == A_MATCH) match_q <= reg_wdata;
      end
   end

   tmt_prescale #(.PTV_W(PTV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .srst(srst), .clr(wr_ctrl),
      .run(ctrl_q.run), .fclk_en(fclk_en), .pre_en(ctrl_q.pre_en),
      .ptv(ctrl_q.ptv), .tick(tick));

   tmt_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick),
      .cmp_en(ctrl_q.cmp_en), .ld(wr_cnt || wr_trig),
      .ld_val(wr_cnt ? reg_wdata : load_q), .load_q(load_q),
      .match_q(match_q), .cnt_q(cnt_q), .ovf(ovf), .mat(mat));

   tmt_events #(.N(NUM_EV)) u_ev (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ev(ev),
      .wr_stat(reg_wr && reg_addr == A_STAT),
      .wr_ien(reg_wr && reg_addr == A_IEN),
      .wr_wen(reg_wr && reg_addr == A_WEN),
      .wbits(reg_wdata[NUM_EV-1:0]), .status(status), .ien(ien),
      .wen(wen), .irq(irq), .wake(wake));

   tmt_pin u_pin (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ctrl_wr(wr_ctrl),
      .wr_dflt(reg_wdata[7]), .pmode(ctrl_q.pmode),
      .toggle(ctrl_q.toggle), .dflt(ctrl_q.dflt), .dir_in(ctrl_q.dir_in),
      .ovf(ovf), .mat(mat), .pin_out(pin_out), .pin_oe(pin_oe));

   always_comb begin
      case (reg_addr)
         A_RDONE: reg_rdata = CNT_W'(1);
         A_STAT:  reg_rdata = CNT_W'(status);
         A_IEN:   reg_rdata = CNT_W'(ien);
         A_WEN:   reg_rdata = CNT_W'(wen);
         A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
         A_CNT:   reg_rdata = cnt_q;
         A_LOAD:  reg_rdata = load_q;
         A_MATCH: reg_rdata = match_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker
   import tmt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fclk_en,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [2:0]        wlow,
   input logic              irq,
   input logic              wake,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  load_q,
   input logic [2:0]        status,
   input logic [2:0]        ien,
   input logic [2:0]        wen,
   input logic              run,
   input logic              reload,
   input logic              ovf,
   input logic              mat
);
   logic wr_stat, wr_srst;
   assign wr_stat = reg_wr && reg_addr == ADDR_W'(OFS_STAT);
   assign wr_srst = reg_wr && wlow[1] &&
                    (reg_addr == ADDR_W'(OFS_CFG) || reg_addr == ADDR_W'(OFS_IFC));

   assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reg_wr) |=> $stable(cnt_q));
   assert_hold_no_fclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fclk_en && !reg_wr) |=> $stable(cnt_q));
   assert_no_event_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!ovf && !mat));
   assert_reload_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !reg_wr) |=> cnt_q == $past(load_q));
   assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !reload && !reg_wr) |=> !run);
   assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wlow == 3'b111 && !ovf && !mat) |=> status == 3'b000);
   assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(({1'b0, ovf, mat} & ien) != 3'b000));
   assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(({1'b0, ovf, mat} & wen) != 3'b000));
   assert_soft_reset_R14: assert property (@(posedge clk) disable iff (!rst_n)
      wr_srst |=> (cnt_q == '0 && status == 3'b000 && !irq && !run));
endmodule

bind tick_match_timer tmt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .wlow(reg_wdata[2:0]), .irq(irq), .wake(wake),
   .cnt_q(cnt_q), .load_q(load_q), .status(status), .ien(ien), .wen(wen),
   .run(ctrl_q.run), .reload(ctrl_q.reload), .ovf(ovf), .mat(mat));

// File: tb/tick_match_timer_tb.sv
`timescale 1ns/1ps
module tick_match_timer_tb;
   localparam int MAX_CYC = 150000;

   logic        clk = 1'b0, rst_n = 1'b0, fclk_en = 1'b0, reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        irq, wake, pin_out, pin_oe;

   int n_chk = 0, n_fail = 0;

   // reference state, updated from the requirements at each edge
   logic [14:0] m_ctrl;
   logic [31:0] m_cnt, m_load, m_match;
   logic [7:0]  m_pcnt;
   logic [2:0]  m_stat, m_ien, m_wen;
   logic        m_wake, m_tog, m_pls;

   always #2 clk = ~clk;

   tick_match_timer u_dut (
      .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .wake(wake), .pin_out(pin_out), .pin_oe(pin_oe));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic mdl_clear();
      m_ctrl = '0; m_cnt = '0; m_load = '0; m_match = '0; m_pcnt = '0;
      m_stat = '0; m_ien = '0; m_wen = '0; m_wake = 0; m_tog = 0; m_pls = 0;
   endtask

   function automatic logic [31:0] mdl_read(input logic [7:0] a);
      case (a)
         8'h14: return 32'd1;
         8'h18: return {29'd0, m_stat};
         8'h1C: return {29'd0, m_ien};
         8'h20: return {29'd0, m_wen};
         8'h24: return {17'd0, m_ctrl};
         8'h28: return m_cnt;
         8'h2C: return m_load;
         8'h38: return m_match;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string read_tag(input logic [7:0] a);
      case (a)
         8'h18: return "R6";
         8'h1C, 8'h20, 8'h24: return "R7";
         8'h28: return "R2";
         8'h2C, 8'h38: return "R9";
         default: return "R1";
      endcase
   endfunction

   function automatic logic mdl_pin();
      if (m_ctrl[11:10] == 2'd0 || m_ctrl[11:10] == 2'd3) return m_ctrl[7];
      if (m_ctrl[12]) return m_tog;
      return m_ctrl[7] ^ m_pls;
   endfunction

   task automatic mdl_edge(input logic wr, input logic [7:0] a,
                           input logic [31:0] d, input logic fe);
      int  lim;
      logic adv, tick, ovf, mat, hit, act, srst;
      logic [31:0] nxt;
      logic [2:0]  ev;
      lim  = (1 << (int'(m_ctrl[4:2]) + 1)) - 1;
      srst = wr && (a == 8'h10 || a == 8'h40) && d[1];
      adv  = m_ctrl[0] && fe;
      tick = adv && (!m_ctrl[5] || int'(m_pcnt) == lim);
      ovf  = tick && m_cnt == 32'hFFFF_FFFF;
      nxt  = ovf ? m_load : m_cnt + 32'd1;
      mat  = tick && m_ctrl[6] && nxt == m_match;
      ev   = {1'b0, ovf, mat};
      hit  = (m_ctrl[11:10] == 2'd1 && ovf) || (m_ctrl[11:10] == 2'd2 && (ovf || mat));
      act  = hit && !m_ctrl[14];
      if (srst) begin mdl_clear(); return; end
      if (wr && a == 8'h24) m_pcnt = '0;
      else if (adv && m_ctrl[5]) m_pcnt = (int'(m_pcnt) == lim) ? 8'd0 : m_pcnt + 8'd1;
      if (wr && a == 8'h28) m_cnt = d;
      else if (wr && a == 8'h30) m_cnt = m_load;
      else if (tick) m_cnt = nxt;
      m_stat = (m_stat & ~((wr && a == 8'h18) ? d[2:0] : 3'd0)) | (ev & m_ien);
      m_wake = |(ev & m_wen);
      m_pls  = act && !m_ctrl[12];
      if (wr && a == 8'h24) m_tog = d[7];
      else if (act && m_ctrl[12]) m_tog = ~m_tog;
      if (wr && a == 8'h24) m_ctrl = d[14:0];
      else if (ovf && !m_ctrl[1]) m_ctrl[0] = 1'b0;
      if (wr && a == 8'h1C) m_ien = d[2:0];
      if (wr && a == 8'h20) m_wen = d[2:0];
      if (wr && a == 8'h2C) m_load = d;
      if (wr && a == 8'h38) m_match = d;
   endtask

   // one cycle: drive at the falling edge, compare, then follow the rising edge
   task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic fe);
      string ptag;
      reg_wr = wr; reg_addr = a; reg_wdata = d; fclk_en = fe;
      #1;
      ptag = (m_ctrl[11:10] == 2'd0 || m_ctrl[11:10] == 2'd3) ? "R10" :
             (m_ctrl[12] ? "R11" : "R12");
      chk(irq == (m_stat != 3'd0), "R6 irq", {31'd0, irq}, {31'd0, m_stat != 3'd0});
      chk(wake == m_wake, "R8 wake", {31'd0, wake}, {31'd0, m_wake});
      chk(pin_oe == !m_ctrl[14], "R13 pin_oe", {31'd0, pin_oe}, {31'd0, !m_ctrl[14]});
      chk(pin_out == mdl_pin(), ptag, {31'd0, pin_out}, {31'd0, mdl_pin()});
      chk(reg_rdata == mdl_read(a), read_tag(a), reg_rdata, mdl_read(a));
      @(posedge clk);
      mdl_edge(wr, a, d, fe);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b1);
   endtask

   task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp,
                            input string tag);
      reg_wr = 0; reg_addr = a; #1;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
      cyc(1'b0, a, 32'd0, 1'b1);
   endtask

   function automatic logic [31:0] near_value();
      case ($urandom % 3)
         0: return $urandom % 24;
         1: return 32'hFFFF_FFE8 + ($urandom % 24);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      mdl_clear();
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd_expect(8'h14, 32'd1, "R1 reset-done");
      rd_expect(8'h34, 32'd0, "R1 write-pending");
      rd_expect(8'h24, 32'd0, "R1 control");
      chk(pin_oe && !pin_out && !irq && !wake, "R1 outputs",
          {28'd0, pin_oe, pin_out, irq, wake}, 32'h8);

      // R3: prescale 2^(2+1) = 8 enabled cycles per step
      wr(8'h24, 32'h0000_0029);
      repeat (40) cyc(1'b0, 8'h28, 32'd0, 1'b1);
      rd_expect(8'h28, 32'd5, "R3 prescaled count");

      // R4: wrap with auto-reload off
      wr(8'h2C, 32'h0000_0100);
      wr(8'h24, 32'h0000_0001);
      wr(8'h28, 32'hFFFF_FFFE);
      cyc(1'b0, 8'h28, 32'd0, 1'b1);
      cyc(1'b0, 8'h28, 32'd0, 1'b1);
      rd_expect(8'h28, 32'h0000_0100, "R4 reload value");
      rd_expect(8'h24, 32'h0000_0000, "R4 run cleared");

      // R5 / R6: match event, interrupt, write-one-to-clear
      wr(8'h1C, 32'hFFFF_FFF9);
      rd_expect(8'h1C, 32'd1, "R7 enable low bits");
      wr(8'h38, 32'd10);
      wr(8'h24, 32'h0000_0041);
      wr(8'h28, 32'd5);
      repeat (5) cyc(1'b0, 8'h18, 32'd0, 1'b1);
      rd_expect(8'h18, 32'd1, "R5 match status");
      chk(irq, "R6 irq after match", {31'd0, irq}, 32'd1);
      wr(8'h18, 32'd1);
      rd_expect(8'h18, 32'd0, "R6 cleared");

      // R9: trigger copies load into the counter
      wr(8'h24, 32'd0);
      wr(8'h30, 32'd0);
      rd_expect(8'h28, 32'h0000_0100, "R9 trigger reload");

      // R14: soft reset through interface control
      wr(8'h20, 32'd7);
      wr(8'h40, 32'd2);
      rd_expect(8'h20, 32'd0, "R14 soft reset");
      rd_expect(8'h2C, 32'd0, "R14 load cleared");

      // constrained random traffic
      for (int i = 0; i < 30000; i++) begin
         int op;
         logic fe;
         logic [31:0] d;
         op = $urandom % 32;
         fe = ($urandom % 4) != 0;
         case (op)
            0, 1: begin
               d = $urandom & 32'h7FFF;
               d[0] = ($urandom % 5) != 0;
               if ($urandom % 2) d[4:2] = 3'($urandom % 2);
               cyc(1'b1, 8'h24, d, fe);
            end
            2, 3: cyc(1'b1, 8'h28, near_value(), fe);
            4:    cyc(1'b1, 8'h2C, near_value(), fe);
            5:    cyc(1'b1, 8'h38, near_value(), fe);
            6:    cyc(1'b1, 8'h18, $urandom, fe);
            7:    cyc(1'b1, 8'h1C, $urandom, fe);
            8:    cyc(1'b1, 8'h20, $urandom, fe);
            9:    cyc(1'b1, 8'h30, $urandom, fe);
            10:   if ($urandom % 16 == 0)
                     cyc(1'b1, (($urandom % 2) != 0) ? 8'h10 : 8'h40, $urandom, fe);
                  else cyc(1'b0, 8'h10, 32'd0, fe);
            default: begin
               logic [7:0] ra;
               case ($urandom % 8)
                  0: ra = 8'h18; 1: ra = 8'h1C; 2: ra = 8'h24; 3: ra = 8'h2C;
                  4: ra = 8'h38; 5: ra = 8'h34; 6: ra = 8'h14;
                  default: ra = 8'h28;
               endcase
               cyc(1'b0, ra, 32'd0, fe);
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", MAX_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule